// File: doc/BRIEF.md
# Sub-Word Store Aligner and Byte Mask

This block sits in front of a 32-bit block RAM that accepts a per-byte write enable. A store arrives as a value (the low bits of a wider accumulator), a 16-bit logical address and a strobe. The two top address bits pick a width window: full word, halfword, byte or nibble. The block places the value in the right byte lanes of the RAM word and produces the matching byte write mask. Partial stores are therefore done by the RAM's byte enables alone, with no read-modify-write.

Only word, halfword and byte stores are carried out. A store into the nibble window is refused: it gets an empty mask and a flag. The data path does not depend on the low address bits. The value is replicated across the word according to the width, and the mask selects which copy is written. Bytes that are not enabled carry no meaning.

Both outputs are registered once. The RAM sees the write one clock after the store is presented.

Top module: `sw_store_align`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, `wr_mask_o` is 0000 and `st_ignored_o` is 0.
- R2: A cycle with `st_valid_i` low gives `wr_mask_o` = 0000 and `st_ignored_o` = 0 one clock later, whatever the address.
- R3: A store with address bits [15:14] = 00 gives mask 1111, with byte lane k (bits 8k+7:8k) equal to value bits 8k+7:8k.
- R4: A store with address bits [15:14] = 01 writes value bits [15:0] to data bits [15:0] with mask 0011 when address bit 0 is 0, and to data bits [31:16] with mask 1100 when bit 0 is 1.
- R5: A store with address bits [15:14] = 10 writes value bits [7:0] to byte lane k = address bits [1:0], with mask 0001, 0010, 0100 or 1000 for k = 0, 1, 2, 3.
- R6: A store with address bits [15:14] = 11 gives mask 0000 and sets `st_ignored_o` to 1 for one cycle.
- R7: Outputs change only at a clock edge and reflect the inputs sampled at the previous edge (one cycle of latency).
- R8: Address bits [13:3], and the low address bits a window does not use for lane selection, have no effect on the mask or the enabled data bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store strobe |
| st_addr_i | input | 16 | Logical store address; bits [15:14] select the width window |
| st_value_i | input | 40 | Store value; only the low 32 bits are used |
| wr_data_o | output | 32 | Lane-aligned write data for the RAM |
| wr_mask_o | output | 4 | Byte write enables, bit k enables byte lane k |
| st_ignored_o | output | 1 | Set for one cycle when a nibble-window store was refused |

## Verification
The assertions check on every cycle that an idle strobe gives an empty mask and that a nibble store gives an empty mask with the flag set. They also check that the mask always has zero, one, two or four bits set and that a word store copies the full value a cycle later. Where the halfword and byte lanes land for each low-address pattern, that the middle address bits are ignored, and the exact one-cycle timing can be shown only by the bench's sweep. The sweep compares every enabled byte with a value computed from the address.

// File: rtl/sw_store_pkg.sv
package sw_store_pkg;

    typedef enum logic [1:0] {
        WIN_WORD   = 2'b00,
        WIN_HALF   = 2'b01,
        WIN_BYTE   = 2'b10,
        WIN_NIBBLE = 2'b11
    } win_e;

    typedef enum logic [1:0] {
        LANE_DIRECT = 2'b00,
        LANE_HALF   = 2'b01,
        LANE_BYTE   = 2'b10
    } lane_sel_e;

endpackage

// File: rtl/sw_store_mask_dec.sv
module sw_store_mask_dec
    import sw_store_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             valid_i,
    input  win_e             win_i,
    input  logic [1:0]       lo_i,
    output logic [LANES-1:0] mask_o,
    output logic             ignored_o,
    output lane_sel_e        sel_o
);

    localparam int HALF_LANES = LANES / 2;

    // Window selects which lanes may be written; low bits pick among them.
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam logic [1:0] LANE_IDX = 2'(j);
        localparam logic       HALF_IDX = (j >= HALF_LANES);
        logic hit;
        always_comb begin
            unique case (win_i)
                WIN_WORD: hit = 1'b1;
                WIN_HALF: hit = (lo_i[0] == HALF_IDX);
                WIN_BYTE: hit = (lo_i == LANE_IDX);
                default:  hit = 1'b0;
            endcase
        end
        assign mask_o[j] = valid_i & hit;
    end

    assign ignored_o = valid_i & (win_i == WIN_NIBBLE);

    always_comb begin
        unique case (win_i)
            WIN_HALF: sel_o = LANE_HALF;
            WIN_BYTE: sel_o = LANE_BYTE;
            default:  sel_o = LANE_DIRECT;
        endcase
    end

endmodule

// File: rtl/sw_store_lane_shift.sv
module sw_store_lane_shift
    import sw_store_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] value_i,
    input  lane_sel_e         sel_i,
    output logic [DATA_W-1:0] data_o
);

    localparam int LANES  = DATA_W / 8;
    localparam int HALF_W = DATA_W / 2;

    // Three-way choice per byte: direct, halfword copy, or byte copy.
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam int DIR_LO  = 8 * j;
        localparam int HALF_LO = 8 * j - ((j >= LANES / 2) ? HALF_W : 0);
        always_comb begin
            unique case (sel_i)
                LANE_HALF: data_o[DIR_LO +: 8] = value_i[HALF_LO +: 8];
                LANE_BYTE: data_o[DIR_LO +: 8] = value_i[7:0];
                default:   data_o[DIR_LO +: 8] = value_i[DIR_LO +: 8];
            endcase
        end
    end

endmodule

// File: rtl/sw_store_align.sv
module sw_store_align
    import sw_store_pkg::*;
#(
    parameter int VAL_W  = 40,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic [VAL_W-1:0]  st_value_i,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [DATA_W/8-1:0] wr_mask_o,
    output logic              st_ignored_o
);

    localparam int LANES = DATA_W / 8;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  mask;
        logic              ignored;
    } out_t;

    out_t      out_d, out_q;
    win_e      win;
    lane_sel_e sel;
    logic [DATA_W-1:0] shifted;
    logic [LANES-1:0]  mask;
    logic              ignored;

    logic unused_bits;
    assign unused_bits = ^{st_value_i[VAL_W-1:DATA_W], st_addr_i[ADDR_W-3:2]};

    assign win = win_e'(st_addr_i[ADDR_W-1:ADDR_W-2]);

    sw_store_mask_dec #(.LANES(LANES)) mask_dec_i (
        .valid_i   (st_valid_i),
        .win_i     (win),
        .lo_i      (st_addr_i[1:0]),
        .mask_o    (mask),
        .ignored_o (ignored),
        .sel_o     (sel)
    );

    sw_store_lane_shift #(.DATA_W(DATA_W)) lane_shift_i (
        .value_i (st_value_i[DATA_W-1:0]),
        .sel_i   (sel),
        .data_o  (shifted)
    );

    always_comb begin
        out_d         = out_q;
        out_d.data    = shifted;
        out_d.mask    = mask;
        out_d.ignored = ignored;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign wr_data_o    = out_q.data;
    assign wr_mask_o    = out_q.mask;
    assign st_ignored_o = out_q.ignored;

    // R2: idle strobe leaves the RAM untouched next cycle
    a_r2_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid_i |=> (wr_mask_o == '0 && !st_ignored_o));

    // R6: nibble-window store is refused
    a_r6_nibble_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid_i && st_addr_i[ADDR_W-1:ADDR_W-2] == 2'b11)
        |=> (wr_mask_o == '0 && st_ignored_o));

    // R3: word store writes every lane with the full value
    a_r3_word_full: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid_i && st_addr_i[ADDR_W-1:ADDR_W-2] == 2'b00)
        |=> (wr_mask_o == '1 && wr_data_o == $past(st_value_i[DATA_W-1:0])));

    // R4 R5: mask is empty, one byte, a halfword, or the whole word
    a_r5_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(wr_mask_o) inside {0, 1, 2, LANES}));

    // R6: a refused store never carries an enable
    a_r6_flag_no_mask: assert property (@(posedge clk) disable iff (!rst_n)
        st_ignored_o |-> wr_mask_o == '0);

endmodule

// File: tb/sw_store_align_tb.sv
module sw_store_align_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid_i = 1'b0;
    logic [15:0] st_addr_i = '0;
    logic [39:0] st_value_i = '0;
    logic [31:0] wr_data_o;
    logic [3:0]  wr_mask_o;
    logic        st_ignored_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sw_store_align dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .st_valid_i   (st_valid_i),
        .st_addr_i    (st_addr_i),
        .st_value_i   (st_value_i),
        .wr_data_o    (wr_data_o),
        .wr_mask_o    (wr_mask_o),
        .st_ignored_o (st_ignored_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string win_req(int w);
        case (w)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Drive at a falling edge, check at the next falling edge.
    task automatic apply(bit v, int w, int mid, int lo, logic [39:0] val);
        int n, s;
        logic [3:0] emask;
        logic       eign;
        string      req;
        @(negedge clk);
        st_valid_i = v;
        st_addr_i  = 16'((w << 14) | (mid << 3) | lo);
        st_value_i = val;
        @(negedge clk);
        case (w)
            0: begin n = 4; s = 0; end
            1: begin n = 2; s = 2 * (lo & 1); end
            2: begin n = 1; s = lo & 3; end
            default: begin n = 0; s = 0; end
        endcase
        emask = v ? 4'(((1 << n) - 1) << s) : 4'b0000;
        eign  = v && (w == 3);
        req   = v ? win_req(w) : "R2";
        if (mid != 0) req = {req, "/R8"};
        check({req, " mask"}, 32'(wr_mask_o), 32'(emask));
        check({req, " ignored"}, 32'(st_ignored_o), 32'(eign));
        for (int j = 0; j < 4; j++) begin
            if (emask[j]) begin
                check({req, " data"}, 32'(wr_data_o[8*j +: 8]),
                      32'((val >> (8 * (j - s))) & 40'hFF));
            end
        end
    endtask

    initial begin
        logic [39:0] vals [4];
        int mids [3];
        vals[0] = 40'hA5_1234_5678;
        vals[1] = 40'h00_89AB_CDEF;
        vals[2] = 40'hFF_FFFF_FFFF;
        vals[3] = 40'h5A_0F1E_2D3C;
        mids[0] = 0; mids[1] = 11'h555; mids[2] = 11'h2AA;

        // R1: reset state
        #2;
        check("R1 mask", 32'(wr_mask_o), 32'h0);
        check("R1 ignored", 32'(st_ignored_o), 32'h0);
        repeat (3) @(posedge clk);
        check("R1 mask held", 32'(wr_mask_o), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < 2; v++)
            for (int w = 0; w < 4; w++)
                for (int lo = 0; lo < 8; lo++)
                    for (int m = 0; m < 3; m++)
                        for (int k = 0; k < 4; k++)
                            apply(v[0], w, mids[m], lo, vals[k]);

        // R7: output holds until the next edge, then follows
        apply(1'b1, 0, 0, 0, vals[0]);
        @(negedge clk);
        st_valid_i = 1'b0;
        #1;
        check("R7 hold before edge", 32'(wr_mask_o), 32'hF);
        @(posedge clk);
        #1;
        check("R7 update after edge", 32'(wr_mask_o), 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule